// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit with Signed Overflow Flag

This block is the integer execution datapath of a small load-store processor. It takes two 32-bit operands and a 4-bit operation code. It produces a 32-bit result, a flag that is set when the result is all zeros, and a flag for signed overflow. It covers add and subtract in trapping and non-trapping forms, four bitwise functions, and signed and unsigned set-on-less-than. A single ripple-carry adder serves add, subtract and both comparisons. Subtraction feeds the adder the inverted B operand with a carry-in of one.

Immediate extension is done before operands reach this block, and exception handling is done after it. The overflow flag is only a request that a later stage may act on. The datapath itself is combinational. The top level registers the three outputs, so every result appears one clock after its operands, and a synchronous active-high reset gives the outputs a defined state.

Top module: `int_alu`

## Requirements
- R1: Code 0x0 (add) and code 0x1 (add, non-trapping) give A+B modulo 2^32.
- R2: Code 0x2 (subtract) and code 0x3 (subtract, non-trapping) give A−B modulo 2^32, formed as A + ~B + 1.
- R3: For code 0x0, `overflow` is 1 exactly when A and B have the same bit 31 and the sum's bit 31 differs from it.
- R4: For code 0x2, `overflow` is 1 exactly when A and B differ in bit 31 and the difference's bit 31 differs from A's.
- R5: Codes 0x1 and 0x3 never set `overflow`, even when the signed result wraps.
- R6: Codes 0x4, 0x5, 0x6 and 0x7 give A AND B, A OR B, A XOR B and NOT(A OR B), with `overflow` 0.
- R7: Code 0xA gives 1 in bit 0 when A < B as two's complement numbers and 0 otherwise. Bits 31..1 are zero, `overflow` is 0, and the answer is correct even when A−B overflows.
- R8: Code 0xB gives 1 in bit 0 when A < B as unsigned numbers and 0 otherwise. Bits 31..1 are zero and `overflow` is 0.
- R9: `zero` is 1 exactly when the 32-bit result is zero.
- R10: Codes 0x8, 0x9 and 0xC–0xF give a zero result with `overflow` 0.
- R11: Outputs reflect the inputs sampled at the previous rising clock edge. While `rst` is high at an edge, the outputs become result 0, `zero` 1 and `overflow` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sel | input | 4 | Operation code |
| result | output | 32 | Registered result |
| zero | output | 1 | Registered all-zeros flag |
| overflow | output | 1 | Registered signed overflow flag |

## Verification
The bench targets signed comparisons where the internal difference overflows, such as 0x80000000 against 0x7FFFFFFF. A design that reads only the sign bit of the difference gives the inverted answer in these cases.

It checks that the non-trapping add and subtract codes stay silent on the same wrapping operands that set the flag on the trapping codes. A decoder that keys on the arithmetic class instead of the exact code would raise `overflow` for them.

It runs the unsigned compare on operands whose signed order differs from their unsigned order, which exposes an inverted carry-out test. It also feeds the unused codes operands that would give nonzero results, so a decoder that falls through to an active unit shows leftover bits.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_ADDU = 4'h1,
        OP_SUB  = 4'h2,
        OP_SUBU = 4'h3,
        OP_AND  = 4'h4,
        OP_OR   = 4'h5,
        OP_XOR  = 4'h6,
        OP_NOR  = 4'h7,
        OP_SLT  = 4'hA,
        OP_SLTU = 4'hB
    } alu_op_e;

    typedef enum logic [1:0] {
        UNIT_ARITH = 2'd0,
        UNIT_LOGIC = 2'd1,
        UNIT_CMP   = 2'd2,
        UNIT_NONE  = 2'd3
    } alu_unit_e;

    typedef struct packed {
        alu_unit_e unit;
        logic      invert_b;
        logic      trap_en;
        logic      cmp_signed;
        logic [1:0] logic_fn;
    } alu_ctrl_t;

    function automatic alu_ctrl_t alu_decode(input logic [3:0] sel);
        alu_ctrl_t c;
        c.unit       = UNIT_NONE;
        c.invert_b   = 1'b0;
        c.trap_en    = 1'b0;
        c.cmp_signed = 1'b0;
        c.logic_fn   = sel[1:0];
        case (sel)
            OP_ADD:  begin c.unit = UNIT_ARITH; c.trap_en = 1'b1; end
            OP_ADDU: begin c.unit = UNIT_ARITH; end
            OP_SUB:  begin c.unit = UNIT_ARITH; c.invert_b = 1'b1; c.trap_en = 1'b1; end
            OP_SUBU: begin c.unit = UNIT_ARITH; c.invert_b = 1'b1; end
            OP_AND, OP_OR, OP_XOR, OP_NOR: c.unit = UNIT_LOGIC;
            OP_SLT:  begin c.unit = UNIT_CMP; c.invert_b = 1'b1; c.cmp_signed = 1'b1; end
            OP_SLTU: begin c.unit = UNIT_CMP; c.invert_b = 1'b1; end
            default: c.unit = UNIT_NONE;
        endcase
        return c;
    endfunction

    function automatic logic fa_sum(input logic x, input logic y, input logic ci);
        return x ^ y ^ ci;
    endfunction

    function automatic logic fa_carry(input logic x, input logic y, input logic ci);
        return (x & y) | (x & ci) | (y & ci);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         invert,
    output logic [W-1:0] sum,
    output logic         carry_out,
    output logic         signed_ovf
);
    logic [W:0]   chain;
    logic [W-1:0] b_eff;

    assign chain[0] = invert;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign b_eff[i]     = b[i] ^ invert;
        assign sum[i]       = fa_sum(a[i], b_eff[i], chain[i]);
        assign chain[i+1]   = fa_carry(a[i], b_eff[i], chain[i]);
    end

    assign carry_out  = chain[W];
    assign signed_ovf = chain[W] ^ chain[W-1];

    // R2: subtracting a value from itself always lands on zero with carry out
    always_comb begin
        if (invert && (a == b)) begin
            assert_self_diff_R2: assert (sum == '0 && carry_out == 1'b1)
                else $error("self difference not zero");
        end
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   fn,
    output logic [W-1:0] y
);
    always_comb begin
        case (fn)
            2'd0:    y = a & b;
            2'd1:    y = a | b;
            2'd2:    y = a ^ b;
            default: y = ~(a | b);
        endcase
    end
endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
    parameter int W = 32
) (
    input  logic         diff_msb,
    input  logic         diff_ovf,
    input  logic         carry_out,
    input  logic         is_signed,
    output logic [W-1:0] y
);
    logic lt;

    assign lt = is_signed ? (diff_msb ^ diff_ovf) : ~carry_out;
    assign y  = {{(W-1){1'b0}}, lt};
endmodule

// File: rtl/int_alu.sv
module int_alu
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [3:0]   op_sel,
    output logic [W-1:0] result,
    output logic         zero,
    output logic         overflow
);
    alu_ctrl_t    ctrl;
    logic [W-1:0] sum_w;
    logic         cout_w;
    logic         sovf_w;
    logic [W-1:0] logic_w;
    logic [W-1:0] cmp_w;
    logic [W-1:0] res_c;
    logic         ovf_c;

    assign ctrl = alu_decode(op_sel);

    alu_addsub #(.W(W)) u_addsub (
        .a          (op_a),
        .b          (op_b),
        .invert     (ctrl.invert_b),
        .sum        (sum_w),
        .carry_out  (cout_w),
        .signed_ovf (sovf_w)
    );

    alu_logic #(.W(W)) u_logic (
        .a  (op_a),
        .b  (op_b),
        .fn (ctrl.logic_fn),
        .y  (logic_w)
    );

    alu_compare #(.W(W)) u_cmp (
        .diff_msb  (sum_w[W-1]),
        .diff_ovf  (sovf_w),
        .carry_out (cout_w),
        .is_signed (ctrl.cmp_signed),
        .y         (cmp_w)
    );

    always_comb begin
        case (ctrl.unit)
            UNIT_ARITH: res_c = sum_w;
            UNIT_LOGIC: res_c = logic_w;
            UNIT_CMP:   res_c = cmp_w;
            default:    res_c = '0;
        endcase
        ovf_c = ctrl.trap_en & sovf_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result   <= '0;
            zero     <= 1'b1;
            overflow <= 1'b0;
        end else begin
            result   <= res_c;
            zero     <= (res_c == '0);
            overflow <= ovf_c;
        end
    end

    assert_zero_flag_R9: assert property (@(posedge clk) disable iff (rst)
        zero |-> (result == '0))
        else $error("zero flag with nonzero result");

    assert_trap_codes_R5: assert property (@(posedge clk) disable iff (rst)
        (overflow && !$past(rst)) |-> ($past(op_sel) == OP_ADD || $past(op_sel) == OP_SUB))
        else $error("overflow on non-trapping code");

    assert_cmp_upper_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(op_sel) == OP_SLT || $past(op_sel) == OP_SLTU))
            |-> (result[W-1:1] == '0 && !overflow))
        else $error("compare result has upper bits");

    assert_unused_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(op_sel) == 4'h8 || $past(op_sel) == 4'h9 || $past(op_sel) >= 4'hC))
            |-> (result == '0 && !overflow))
        else $error("unused code produced output");

    assert_reset_state_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (result == '0 && zero && !overflow))
        else $error("reset state wrong");
endmodule

// File: tb/int_alu_bench.sv
`timescale 1ns/1ps
module int_alu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [3:0]  op_sel = '0;
    logic [31:0] result;
    logic        zero;
    logic        overflow;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [33:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    int_alu u_int_alu (
        .clk      (clk),
        .rst      (rst),
        .op_a     (op_a),
        .op_b     (op_b),
        .op_sel   (op_sel),
        .result   (result),
        .zero     (zero),
        .overflow (overflow)
    );

    // returns {result, zero, overflow}
    function automatic logic [33:0] model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        logic        o;
        r = '0;
        o = 1'b0;
        case (op)
            4'h0: begin r = a + b; o = (a[31] == b[31]) && (r[31] != a[31]); end
            4'h1: r = a + b;
            4'h2: begin r = a - b; o = (a[31] != b[31]) && (r[31] != a[31]); end
            4'h3: r = a - b;
            4'h4: r = a & b;
            4'h5: r = a | b;
            4'h6: r = a ^ b;
            4'h7: r = ~(a | b);
            4'hA: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            4'hB: r = (a < b) ? 32'd1 : 32'd0;
            default: r = '0;
        endcase
        return {r, (r == 32'd0), o};
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'h0, 4'h1: return "R1";
            4'h2, 4'h3: return "R2";
            4'h4, 4'h5, 4'h6, 4'h7: return "R6";
            4'hA: return "R7";
            4'hB: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b, input string tag);
        @(negedge clk);
        op_sel = op;
        op_a   = a;
        op_b   = b;
        exp_q.push_back(model(op, a, b));
        tag_q.push_back(tag);
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // monitor: compares each registered result one edge after issue
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && exp_q.size() > 0) begin
                logic [33:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if ({result, zero, overflow} !== e) begin
                    bad++;
                    $display("FAIL %s actual res=%h z=%0b v=%0b expected res=%h z=%0b v=%0b",
                             t, result, zero, overflow, e[33:2], e[1], e[0]);
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        logic [3:0] ops [10];
        ops = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hA, 4'hB};

        // R11 reset state with operands that would give nonzero output
        op_sel = 4'h0; op_a = 32'h1; op_b = 32'h7fffffff;
        repeat (3) @(posedge clk);
        #1;
        check_bit("R11 result", result == 32'd0, 1'b1);
        check_bit("R11 zero", zero, 1'b1);
        check_bit("R11 overflow", overflow, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        issue(4'h0, 32'd1, 32'd2, "R1 add");
        issue(4'h1, 32'hffffffff, 32'd1, "R1 addu wrap R9");
        issue(4'h0, 32'h7fffffff, 32'd1, "R3 pos+pos");
        issue(4'h0, 32'h80000000, 32'h80000000, "R3 neg+neg R9");
        issue(4'h0, 32'h7fffffff, 32'h80000000, "R3 mixed signs");
        issue(4'h1, 32'h7fffffff, 32'd1, "R5 addu");
        issue(4'h2, 32'd5, 32'd7, "R2 sub");
        issue(4'h2, 32'h80000000, 32'd1, "R4 neg-pos");
        issue(4'h2, 32'h7fffffff, 32'hffffffff, "R4 pos-neg");
        issue(4'h2, 32'h12345678, 32'h12345678, "R2 self R9");
        issue(4'h3, 32'h80000000, 32'd1, "R5 subu");
        issue(4'h4, 32'hf0f0ff00, 32'h3c3c0ff0, "R6 and");
        issue(4'h5, 32'hf0f0ff00, 32'h3c3c0ff0, "R6 or");
        issue(4'h6, 32'hf0f0ff00, 32'hf0f0ff00, "R6 xor R9");
        issue(4'h7, 32'hf0f0ff00, 32'h0000000f, "R6 nor");
        issue(4'hA, 32'h80000000, 32'h7fffffff, "R7 ovf diff");
        issue(4'hA, 32'h7fffffff, 32'h80000000, "R7 ovf diff rev");
        issue(4'hA, 32'hffffffff, 32'd0, "R7 -1<0");
        issue(4'hA, 32'd9, 32'd9, "R7 equal");
        issue(4'hB, 32'hffffffff, 32'd1, "R8 big");
        issue(4'hB, 32'd1, 32'hffffffff, "R8 small");
        issue(4'hB, 32'h80000000, 32'h80000000, "R8 equal");
        issue(4'h8, 32'hffffffff, 32'hffffffff, "R10 code8");
        issue(4'h9, 32'h7fffffff, 32'd1, "R10 code9");
        issue(4'hC, 32'h12345678, 32'h1, "R10 codeC");
        issue(4'hF, 32'hffffffff, 32'd0, "R10 codeF");

        s = 32'h2545f491;
        for (int i = 0; i < 400; i++) begin
            logic [3:0] op;
            s = s ^ (s << 13);
            s = s ^ (s >> 17);
            s = s ^ (s << 5);
            op = ops[s % 10];
            issue(op, s, {s[15:0], s[31:16]} ^ 32'h9e3779b9, tag_of(op));
        end

        repeat (3) @(posedge clk);
        #1;
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule